// File: doc/BRIEF.md
# Ping-Pong Tiled Convolution Engine

This block evaluates one convolution layer over an output tile in fixed-point arithmetic. A start pulse captures the layer shape: input map count N, output map count M, square kernel size K, window step S, and tile height R and width C. Each tile's weights and input pixels then stream in over a valid/ready load port, one 16-bit word per handshake. They land in one of two on-chip banks. While one bank feeds the multiply-accumulate datapath, the next tile fills the other bank, so tile loading overlaps computation. Because every layer dimension is a run-time input, one build serves every layer of a network.

Each output pixel is the sum of K·K·N products. One product is accumulated per clock in a 40-bit signed accumulator. A finished pixel is offered on a valid/ready output port, and the engine waits for it to be taken before it begins the next pixel. After the last pixel of a tile is accepted, the engine pulses a done flag, frees that bank and moves to the other bank once that bank is full. The shape must fit the banks: M·N·K·K words within the weight depth, and N·IH·IW words within the input depth, where IH = S·(R−1)+K and IW = S·(C−1)+K.

Top module: `conv_engine`

## Requirements
- R1: A start pulse captures the six shape inputs. Later changes on those pins have no effect until the next start. Start also marks both banks empty and aims the next load at bank 0.
- R2: Each tile is loaded as M·N·K·K weights followed by N·IH·IW inputs. The weight for (to, ti, i, j) is stream word ((to·N+ti)·K+i)·K+j. Input pixel (ti, y, x) is weight count + (ti·IH+y)·IW+x.
- R3: Output (to, row, col) equals the sum over ti < N and i, j < K of weight(to, ti, i, j) × input(ti, S·row+i, S·col+j), for K in 3..11 and 1 ≤ S < K, so that windows overlap.
- R4: Outputs leave in the order row outermost, then col, then output map. While out_valid is high and out_ready is low, out_data holds steady and out_valid stays high.
- R5: Accumulation is exact two's complement on 40 bits. This holds up to 484 products of full-scale −32768 operands.
- R6: ld_ready is low whenever the bank due for the next load is still full. A second tile can be loaded while the first one computes.
- R7: Computation starts on a bank only when that bank is full and the previous pass has finished. Tiles produce their outputs in the order they were loaded.
- R8: done is high for exactly one cycle, in the cycle after the handshake that takes the last output of a tile, and at no other time.
- R9: After reset and before the first start, ld_ready, out_valid and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Captures the shape and empties the banks |
| cfg_n | input | 8 | Input map count |
| cfg_m | input | 8 | Output map count |
| cfg_k | input | 8 | Kernel size |
| cfg_s | input | 8 | Window step |
| cfg_r | input | 8 | Tile rows |
| cfg_c | input | 8 | Tile columns |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word can be taken |
| ld_data | input | 16 | Load word, signed |
| out_valid | output | 1 | Output pixel offered |
| out_ready | input | 1 | Output pixel taken |
| out_data | output | 40 | Output pixel, signed |
| done | output | 1 | Tile finished pulse |

## Verification
The bench sweeps several layer shapes: the smallest kernel with unit step, the largest kernel with the largest step below it, and even and odd kernels with mid-size steps. It compares every pixel with a six-loop sum computed in the bench. Windows that overlap, or an address that ignores the step or the map offset, produce wrong sums at row or column edges. A full-scale case made of negative extremes overflows a narrow or sign-dropping accumulator. Output backpressure is random. A design that changes out_data during a stall or drops a word breaks the sequence. In one layer the drain is deliberately held back until two tiles are resident. A design that overwrites a full bank, or that starts on a bank before it is full, shows ld_ready high or corrupts the third tile. Each handshake is followed by a check of done, which exposes a pulse that comes early, comes late or is repeated.

// File: rtl/conv_pkg.sv
package conv_pkg;
    // Width of each shape input pin
    localparam int CFG_W = 8;
    // Width of internal counters and derived sizes
    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t CNT_ONE = cnt_t'(1);

    // Captured layer shape with derived window sizes and word counts
    typedef struct packed {
        cnt_t n;
        cnt_t m;
        cnt_t k;
        cnt_t s;
        cnt_t r;
        cnt_t c;
        cnt_t ih;
        cnt_t iw;
        cnt_t wcnt;
        cnt_t icnt;
    } layer_cfg_t;

    typedef enum logic [1:0] {W_IDLE, W_RUN, W_WAIT} walk_state_e;

    // Zero-extend a shape pin to counter width
    function automatic cnt_t widen(input logic [CFG_W-1:0] v);
        return {{(CNT_W-CFG_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/conv_loader.sv
// Load-side sequencer. It writes the stream into the bank picked by a
// ping-pong pointer and tracks which bank holds a complete tile.
// Assumes the word counts fit the bank depths.
module conv_loader
    import conv_pkg::*;
#(
    parameter int DW  = 16,
    parameter int WAW = 10,
    parameter int IAW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           cfg_loaded,
    input  cnt_t           wcnt,
    input  cnt_t           icnt,
    input  logic           ld_valid,
    output logic           ld_ready,
    input  logic [DW-1:0]  ld_data,
    input  logic           clr_full,
    input  logic           clr_bank,
    output logic           wr_en,
    output logic           wr_bank,
    output logic           wr_is_wt,
    output logic [WAW-1:0] wr_waddr,
    output logic [IAW-1:0] wr_iaddr,
    output logic [DW-1:0]  wr_data,
    output logic [1:0]     bank_full
);
    cnt_t ptr;
    cnt_t total;
    cnt_t in_off;
    logic ld_bank;

    // Decode the stream position into a write target
    always_comb begin
        total    = wcnt + icnt;
        in_off   = ptr - wcnt;
        ld_ready = cfg_loaded && !bank_full[ld_bank];
        wr_en    = ld_valid && ld_ready;
        wr_bank  = ld_bank;
        wr_is_wt = ptr < wcnt;
        wr_waddr = WAW'(ptr);
        wr_iaddr = IAW'(in_off);
        wr_data  = ld_data;
    end

    // Advance the stream pointer and keep the per-bank full flags
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            ptr       <= '0;
            ld_bank   <= 1'b0;
            bank_full <= '0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (clr_full && clr_bank == 1'(b)) bank_full[b] <= 1'b0;
            end
            if (wr_en) begin
                if (ptr == total - CNT_ONE) begin
                    ptr                <= '0;
                    bank_full[ld_bank] <= 1'b1;
                    ld_bank            <= ~ld_bank;
                end else begin
                    ptr <= ptr + CNT_ONE;
                end
            end
        end
    end
endmodule

// File: rtl/conv_bank_store.sv
// Two banks, each holding one tile's weights and inputs. The write side
// and the read side address different banks. Reads are registered, so
// data appears one cycle after the address.
module conv_bank_store #(
    parameter int DW       = 16,
    parameter int WT_DEPTH = 1024,
    parameter int IN_DEPTH = 1024,
    localparam int WAW     = $clog2(WT_DEPTH),
    localparam int IAW     = $clog2(IN_DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_bank,
    input  logic           wr_is_wt,
    input  logic [WAW-1:0] wr_waddr,
    input  logic [IAW-1:0] wr_iaddr,
    input  logic [DW-1:0]  wr_data,
    input  logic           rd_bank,
    input  logic [WAW-1:0] rd_waddr,
    input  logic [IAW-1:0] rd_iaddr,
    output logic [DW-1:0]  wt_q,
    output logic [DW-1:0]  in_q
);
    logic rd_bank_q;

    for (genvar b = 0; b < 2; b++) begin : bank_g
        logic [DW-1:0] wmem [WT_DEPTH];
        logic [DW-1:0] imem [IN_DEPTH];
        logic [DW-1:0] wq;
        logic [DW-1:0] iq;

        // Write the selected array and read both arrays of this bank
        always_ff @(posedge clk) begin
            if (wr_en && wr_bank == 1'(b)) begin
                if (wr_is_wt) wmem[wr_waddr] <= wr_data;
                else          imem[wr_iaddr] <= wr_data;
            end
            wq <= wmem[rd_waddr];
            iq <= imem[rd_iaddr];
        end
    end

    // Remember which bank the pending read came from
    always_ff @(posedge clk) begin
        if (!rst_n) rd_bank_q <= 1'b0;
        else        rd_bank_q <= rd_bank;
    end

    assign wt_q = rd_bank_q ? bank_g[1].wq : bank_g[0].wq;
    assign in_q = rd_bank_q ? bank_g[1].iq : bank_g[0].iq;
endmodule

// File: rtl/conv_walker.sv
// Loop-nest sequencer. It walks row, col, output map, input map, kernel
// row and kernel column, and issues one term address per cycle. After the
// last term of a pixel it waits for that pixel to be taken. It owns the
// compute bank pointer and releases the bank at the end of a pass.
module conv_walker
    import conv_pkg::*;
#(
    parameter int WAW = 10,
    parameter int IAW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  cnt_t           n,
    input  cnt_t           m,
    input  cnt_t           k,
    input  cnt_t           s,
    input  cnt_t           r,
    input  cnt_t           c,
    input  cnt_t           ih,
    input  cnt_t           iw,
    input  logic [1:0]     bank_full,
    input  logic           pix_taken,
    output logic           issue,
    output logic           first_term,
    output logic           last_term,
    output logic           rd_bank,
    output logic [WAW-1:0] rd_waddr,
    output logic [IAW-1:0] rd_iaddr,
    output logic           busy,
    output logic           pass_done
);
    walk_state_e state;
    cnt_t row, col, to, ti, ki, kj;
    cnt_t wa, ia, y, x;
    logic pix_last;
    logic cmp_bank;

    // Term flags and addresses for the current loop position
    always_comb begin
        first_term = (ti == '0) && (ki == '0) && (kj == '0);
        last_term  = (ti == n - CNT_ONE) && (ki == k - CNT_ONE) && (kj == k - CNT_ONE);
        pix_last   = (to == m - CNT_ONE) && (col == c - CNT_ONE) && (row == r - CNT_ONE);
        wa         = ((to * n + ti) * k + ki) * k + kj;
        y          = s * row + ki;
        x          = s * col + kj;
        ia         = (ti * ih + y) * iw + x;
        rd_waddr   = WAW'(wa);
        rd_iaddr   = IAW'(ia);
        rd_bank    = cmp_bank;
        issue      = state == W_RUN;
        busy       = state != W_IDLE;
        pass_done  = (state == W_WAIT) && pix_taken && pix_last;
    end

    // Step the six loops and the bank pointer
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            state    <= W_IDLE;
            cmp_bank <= 1'b0;
            row <= '0; col <= '0; to <= '0;
            ti  <= '0; ki  <= '0; kj <= '0;
        end else begin
            unique case (state)
                W_IDLE: begin
                    if (bank_full[cmp_bank]) begin
                        state <= W_RUN;
                        row <= '0; col <= '0; to <= '0;
                        ti  <= '0; ki  <= '0; kj <= '0;
                    end
                end
                W_RUN: begin
                    if (last_term) begin
                        state <= W_WAIT;
                        ti <= '0; ki <= '0; kj <= '0;
                    end else if (kj != k - CNT_ONE) begin
                        kj <= kj + CNT_ONE;
                    end else begin
                        kj <= '0;
                        if (ki != k - CNT_ONE) begin
                            ki <= ki + CNT_ONE;
                        end else begin
                            ki <= '0;
                            ti <= ti + CNT_ONE;
                        end
                    end
                end
                W_WAIT: begin
                    if (pix_taken) begin
                        if (pix_last) begin
                            state    <= W_IDLE;
                            cmp_bank <= ~cmp_bank;
                        end else begin
                            state <= W_RUN;
                            if (to != m - CNT_ONE) begin
                                to <= to + CNT_ONE;
                            end else begin
                                to <= '0;
                                if (col != c - CNT_ONE) begin
                                    col <= col + CNT_ONE;
                                end else begin
                                    col <= '0;
                                    row <= row + CNT_ONE;
                                end
                            end
                        end
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/conv_engine.sv
// Top of the tiled convolution engine. It captures the layer shape,
// connects the loader, bank store and loop walker, and holds the
// multiply-accumulate stage together with the output register.
// Assumes 1 <= S < K and that the shape fits the bank depths.
module conv_engine
    import conv_pkg::*;
#(
    parameter int DW       = 16,
    parameter int AW       = 40,
    parameter int WT_DEPTH = 1024,
    parameter int IN_DEPTH = 1024,
    localparam int WAW     = $clog2(WT_DEPTH),
    localparam int IAW     = $clog2(IN_DEPTH),
    localparam int PW      = 2 * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CFG_W-1:0] cfg_n,
    input  logic [CFG_W-1:0] cfg_m,
    input  logic [CFG_W-1:0] cfg_k,
    input  logic [CFG_W-1:0] cfg_s,
    input  logic [CFG_W-1:0] cfg_r,
    input  logic [CFG_W-1:0] cfg_c,
    input  logic             ld_valid,
    output logic             ld_ready,
    input  logic [DW-1:0]    ld_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [AW-1:0]    out_data,
    output logic             done
);
    layer_cfg_t cfg, cfg_nx;
    logic cfg_loaded;

    logic           wr_en, wr_bank, wr_is_wt;
    logic [WAW-1:0] wr_waddr, rd_waddr;
    logic [IAW-1:0] wr_iaddr, rd_iaddr;
    logic [DW-1:0]  wr_data, wt_q, in_q;
    logic [1:0]     bank_full;
    logic           cmp_bank, walk_busy, pass_done;
    logic           issue, first_term, last_term, pix_taken;
    logic           s1_valid, s1_first, s1_last;
    logic signed [PW-1:0] wt_ext, in_ext, prod;
    logic signed [AW-1:0] prod_ext, acc, acc_next;

    // Derive window sizes and word counts from the shape pins
    always_comb begin
        cfg_nx.n    = widen(cfg_n);
        cfg_nx.m    = widen(cfg_m);
        cfg_nx.k    = widen(cfg_k);
        cfg_nx.s    = widen(cfg_s);
        cfg_nx.r    = widen(cfg_r);
        cfg_nx.c    = widen(cfg_c);
        cfg_nx.ih   = cfg_nx.s * (cfg_nx.r - CNT_ONE) + cfg_nx.k;
        cfg_nx.iw   = cfg_nx.s * (cfg_nx.c - CNT_ONE) + cfg_nx.k;
        cfg_nx.wcnt = cfg_nx.m * cfg_nx.n * cfg_nx.k * cfg_nx.k;
        cfg_nx.icnt = cfg_nx.n * cfg_nx.ih * cfg_nx.iw;
    end

    // Capture the shape on start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg        <= '0;
            cfg_loaded <= 1'b0;
        end else if (start) begin
            cfg        <= cfg_nx;
            cfg_loaded <= 1'b1;
        end
    end

    conv_loader #(.DW(DW), .WAW(WAW), .IAW(IAW)) u_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_loaded(cfg_loaded),
        .wcnt(cfg.wcnt), .icnt(cfg.icnt),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
        .clr_full(pass_done), .clr_bank(cmp_bank),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_is_wt(wr_is_wt),
        .wr_waddr(wr_waddr), .wr_iaddr(wr_iaddr), .wr_data(wr_data),
        .bank_full(bank_full)
    );

    conv_bank_store #(.DW(DW), .WT_DEPTH(WT_DEPTH), .IN_DEPTH(IN_DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_is_wt(wr_is_wt),
        .wr_waddr(wr_waddr), .wr_iaddr(wr_iaddr), .wr_data(wr_data),
        .rd_bank(cmp_bank), .rd_waddr(rd_waddr), .rd_iaddr(rd_iaddr),
        .wt_q(wt_q), .in_q(in_q)
    );

    assign pix_taken = out_valid && out_ready;

    conv_walker #(.WAW(WAW), .IAW(IAW)) u_walker (
        .clk(clk), .rst_n(rst_n), .start(start),
        .n(cfg.n), .m(cfg.m), .k(cfg.k), .s(cfg.s), .r(cfg.r), .c(cfg.c),
        .ih(cfg.ih), .iw(cfg.iw),
        .bank_full(bank_full), .pix_taken(pix_taken),
        .issue(issue), .first_term(first_term), .last_term(last_term),
        .rd_bank(cmp_bank), .rd_waddr(rd_waddr), .rd_iaddr(rd_iaddr),
        .busy(walk_busy), .pass_done(pass_done)
    );

    // Sign-extended product and the next accumulator value
    always_comb begin
        wt_ext   = {{DW{wt_q[DW-1]}}, wt_q};
        in_ext   = {{DW{in_q[DW-1]}}, in_q};
        prod     = wt_ext * in_ext;
        prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
        acc_next = s1_first ? prod_ext : acc + prod_ext;
    end

    // Align the term flags with the registered bank read
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            s1_valid <= 1'b0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
        end else begin
            s1_valid <= issue;
            s1_first <= first_term;
            s1_last  <= last_term;
        end
    end

    // Accumulate, offer finished pixels and pulse done at the end of a pass
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            acc       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            done      <= 1'b0;
        end else begin
            done <= pass_done;
            if (s1_valid) acc <= acc_next;
            if (s1_valid && s1_last) begin
                out_valid <= 1'b1;
                out_data  <= acc_next;
            end else if (pix_taken) begin
                out_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/conv_engine_chk.sv
// Protocol and bank-state checks for conv_engine, attached by bind.
module conv_engine_chk #(
    parameter int AW = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          out_valid,
    input logic          out_ready,
    input logic [AW-1:0] out_data,
    input logic          done,
    input logic          ld_ready,
    input logic          cfg_loaded,
    input logic          walk_busy,
    input logic [1:0]    bank_full,
    input logic          cmp_bank
);
    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || start)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready));

    // R7
    busy_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_busy |-> bank_full[cmp_bank]);

    // R6
    no_load_both_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ready |-> !(&bank_full));

    // R9
    quiet_before_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_loaded |-> !ld_ready && !out_valid && !done);
endmodule

bind conv_engine conv_engine_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .ld_ready(ld_ready), .cfg_loaded(cfg_loaded),
    .walk_busy(walk_busy), .bank_full(bank_full), .cmp_bank(cmp_bank)
);

// File: tb/conv_engine_test.sv
module conv_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cfg_n = '0, cfg_m = '0, cfg_k = '0, cfg_s = '0, cfg_r = '0, cfg_c = '0;
    logic        ld_valid = 1'b0;
    logic        ld_ready;
    logic [15:0] ld_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [39:0] out_data;
    logic        done;

    int n_cmp = 0, n_bad = 0;
    int cN, cM, cK, cS, cR, cC, cIH, cIW, cW, cI;
    bit extreme = 1'b0;
    int tiles_loaded = 0;
    int done_seen = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    conv_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_n(cfg_n), .cfg_m(cfg_m), .cfg_k(cfg_k), .cfg_s(cfg_s), .cfg_r(cfg_r), .cfg_c(cfg_c),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
    );

    always @(negedge clk) if (done) done_seen++;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int gen(input int seed, input int p);
        if (extreme) return -32768;
        return ((p * 7919 + seed * 104729 + (p * p) % 97) % 2001) - 1000;
    endfunction

    function automatic longint ref_pix(input int seed, input int to, input int row, input int col);
        longint sum = 0;
        for (int ti = 0; ti < cN; ti++)
            for (int i = 0; i < cK; i++)
                for (int j = 0; j < cK; j++) begin
                    longint w = longint'(gen(seed, ((to * cN + ti) * cK + i) * cK + j));
                    longint x = longint'(gen(seed, cW + (ti * cIH + cS * row + i) * cIW + cS * col + j));
                    sum += w * x;
                end
        return sum;
    endfunction

    task automatic feed(input int tiles);
        for (int t = 0; t < tiles; t++) begin
            for (int p = 0; p < cW + cI; p++) begin
                bit hs;
                ld_valid = 1'b1;
                ld_data  = 16'(gen(t * 13 + cK, p));
                do begin
                    hs = ld_ready;
                    @(negedge clk);
                end while (!hs);
            end
            tiles_loaded++;
        end
        ld_valid = 1'b0;
    endtask

    task automatic drain(input int tiles, input bit late, input string tag);
        if (late) begin
            wait (tiles_loaded >= 2);
            repeat (20) @(negedge clk);
            // R6: both banks resident, third tile must be held off
            chk(ld_ready == 1'b0, "R6", "ld_ready with both banks full", longint'(ld_ready), 0);
            // R7: first bank computed and waiting on the output port
            chk(out_valid == 1'b1, "R7", "first pixel pending", longint'(out_valid), 1);
        end
        for (int t = 0; t < tiles; t++) begin
            for (int row = 0; row < cR; row++)
                for (int col = 0; col < cC; col++)
                    for (int to = 0; to < cM; to++) begin
                        longint exp = ref_pix(t * 13 + cK, to, row, col);
                        logic [39:0] exp40 = exp[39:0];
                        bit last = (row == cR - 1) && (col == cC - 1) && (to == cM - 1);
                        bit got = 1'b0;
                        while (!got) begin
                            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                            out_ready = lfsr[0] | lfsr[1];
                            if (out_valid && out_ready) begin
                                string req = (t > 0) ? "R7" : ((row == 0 && col == 0 && to == 0) ? "R1" : tag);
                                chk(out_data == exp40, req, "pixel value",
                                    longint'($signed(out_data)), exp);
                                got = 1'b1;
                                @(negedge clk);
                                out_ready = 1'b0;
                                // R8: done follows only the last handshake of a tile
                                chk(done == last, "R8", "done after handshake", longint'(done), longint'(last));
                            end else begin
                                logic [39:0] held = out_data;
                                bit stalled = out_valid;
                                @(negedge clk);
                                // R4: held word during a stall
                                if (stalled)
                                    chk(out_valid && out_data == held, "R4", "stall hold",
                                        longint'($signed(out_data)), longint'($signed(held)));
                            end
                        end
                    end
        end
    endtask

    task automatic run_layer(input int n, input int m, input int k, input int s,
                             input int r, input int c, input int tiles,
                             input bit xtr, input bit late, input string tag);
        cN = n; cM = m; cK = k; cS = s; cR = r; cC = c;
        cIH = s * (r - 1) + k;
        cIW = s * (c - 1) + k;
        cW = m * n * k * k;
        cI = n * cIH * cIW;
        extreme = xtr;
        tiles_loaded = 0;
        done_seen = 0;
        cfg_n = 8'(n); cfg_m = 8'(m); cfg_k = 8'(k);
        cfg_s = 8'(s); cfg_r = 8'(r); cfg_c = 8'(c);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R1: disturb the shape pins after capture
        cfg_n = 8'd7; cfg_m = 8'd9; cfg_k = 8'd2; cfg_s = 8'd5; cfg_r = 8'd6; cfg_c = 8'd1;
        fork
            feed(tiles);
            drain(tiles, late, tag);
        join
        repeat (3) @(negedge clk);
        // R8: one pulse per tile
        chk(done_seen == tiles, "R8", "done pulse count", longint'(done_seen), longint'(tiles));
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        ld_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R9: quiet until the first start
        chk(ld_ready == 1'b0, "R9", "ld_ready before start", longint'(ld_ready), 0);
        chk(out_valid == 1'b0, "R9", "out_valid before start", longint'(out_valid), 0);
        chk(done == 1'b0, "R9", "done before start", longint'(done), 0);
        ld_valid = 1'b0;

        run_layer(2, 3, 3, 1, 3, 4, 3, 1'b0, 1'b1, "R3");  // R6 late drain, smallest kernel
        run_layer(1, 2, 11, 10, 2, 2, 2, 1'b0, 1'b0, "R2"); // largest kernel and step
        run_layer(3, 2, 5, 2, 3, 3, 2, 1'b0, 1'b0, "R3");
        run_layer(2, 1, 7, 3, 2, 3, 2, 1'b0, 1'b0, "R3");
        run_layer(1, 1, 4, 3, 2, 2, 2, 1'b0, 1'b0, "R3");
        run_layer(4, 2, 11, 1, 1, 1, 2, 1'b1, 1'b0, "R5"); // full-scale accumulation

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule